// File: doc/BRIEF.md
# Register-mapped SPI master

This block is a single-word SPI master driven through a small 32-bit register port. Software picks one of eight chip-select lines and whether it is driven active, sets the clock polarity, the clock phase, the bit order of each direction separately and the word size (8 or 16 bits). Writing the transmit register starts one full-duplex word. When the word completes a done flag is raised and the received word can be read from the receive register.

The serial clock is paced by a one-cycle enable from a separate divider block: every enable moves SCLK by one half period. A programmable capture delay sets how many system clock cycles after a sampling edge the MISO line is latched. This allows a slave whose data arrives late to be read reliably at high serial rates. Writes take effect on the rising clock edge while `bus_valid` and `bus_write` are high. `bus_rdata` always shows the register selected by `bus_addr`.

Top module: `regspi_master`

## Requirements
- R1: After reset all chip-select outputs are high, SCLK and MOSI are low, the done register (0x10) and receive register (0x0C) read 0, and the timing register (0x18) reads 0x40 (capture delay 1).
- R2: Registers read back their written fields with every other bit 0: control 0x00 holds bit 0 (select on) and bits [4:2] (line index); configuration 0x04 holds bit 5 (16-bit words), bit 11 (CPOL), bit 12 (CPHA), bit 13 (transmit LSB first) and bit 14 (receive LSB first); timing 0x18 holds the capture delay in bits [7:6].
- R3: `cs_n` is active low; only the line numbered by control bits [4:2] may be low, and only while control bit 0 is 1.
- R4: While idle SCLK sits at the CPOL level. A word makes exactly two SCLK transitions per bit, one per divider enable, and SCLK is back at CPOL when the word ends.
- R5: With CPHA=0 MISO is sampled on odd SCLK transitions and MOSI moves on even ones, and the first bit is on MOSI before the first transition. With CPHA=1 MOSI moves on odd transitions and sampling is on even ones. MOSI sends bits from the top down unless bit 13 is set.
- R6: The first received bit lands in the top bit of the word unless bit 14 is set, in which case it lands in bit 0.
- R7: With configuration bit 5 clear a word is 8 bits, sent from bits [7:0] of the transmit register, and receive bits [31:8] read 0. With it set a word is 16 bits in bits [15:0].
- R8: A write to 0x08 while idle starts one word and clears done. Register 0x10 reads 1 once the word is complete.
- R9: Writing the value 0 to 0x10 clears done; writing any nonzero value leaves it set.
- R10: A write to 0x08 during a word is ignored: the word being sent, the value read back from 0x08 and the number of SCLK transitions are unchanged.
- R11: MISO is latched d system clock cycles after the sampling clock edge, where d (0 to 3) is timing bits [7:6]. For example, data that a slave presents two cycles after the sampling edge is caught only with d of 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | Write when high together with bus_valid |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| half_tick | input | 1 | Half-period enable from the clock divider |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 8 | Active-low chip selects |

## Verification
A bench slave model follows the SCLK transitions seen at the port, records MOSI on the sampling transitions and feeds a known MISO sequence. Random configurations cover all four clock modes, both word sizes, both independent bit orders and every capture delay. These runs separate errors in edge parity, bit placement and masking of the upper bits. A directed late-slave run in mode 3 presents each MISO bit two cycles after its sampling edge. Delays 0 and 1 must then produce the word shifted by one bit and delays 2 and 3 the true word, which shows whether the delay taps line up. A write to the transmit register in the middle of a word, a nonzero write to the done register and a sweep of all chip-select settings cover the cases that must have no effect.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

  // register byte offsets (software-visible layout)
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_CFG    = 'h04;
  localparam int OFF_TXD    = 'h08;
  localparam int OFF_RXD    = 'h0C;
  localparam int OFF_CAUSE  = 'h10;
  localparam int OFF_TIMING = 'h18;

  // field positions
  localparam int CTRL_ON_BIT   = 0;
  localparam int CTRL_IDX_LO   = 2;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CFG_CPOL_BIT  = 11;
  localparam int CFG_CPHA_BIT  = 12;
  localparam int CFG_TXLSB_BIT = 13;
  localparam int CFG_RXLSB_BIT = 14;
  localparam int TIM_DLY_LO    = 6;
  localparam int DLY_RESET     = 1;

  typedef struct packed {
    logic wide;
    logic cpol;
    logic cpha;
    logic tx_lsb;
    logic rx_lsb;
  } mode_t;

  // number of bits in one word for the selected size
  function automatic int word_bits(logic wide, int narrow, int broad);
    return wide ? broad : narrow;
  endfunction

  // position inside the word of the idx-th bit on the wire
  function automatic int bit_slot(int idx, int n, logic lsb_first);
    return lsb_first ? idx : (n - 1 - idx);
  endfunction

  // k is the 1-based SCLK transition number within the word
  function automatic logic is_sample_edge(int k, logic cpha);
    return ((k % 2) == 1) != cpha;
  endfunction

  function automatic logic is_shift_edge(int k, int n, logic cpha);
    return !is_sample_edge(k, cpha) && (k >= 2) && (k <= 2 * n - 1);
  endfunction

endpackage

// File: rtl/regspi_regs.sv
module regspi_regs
  import regspi_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int MAX_BITS = 16,
  parameter int DLY_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic                finish,
  input  logic [MAX_BITS-1:0] rx_word,
  output logic                cs_on,
  output logic [IDX_W-1:0]    cs_idx,
  output mode_t               mode,
  output logic [DLY_W-1:0]    smp_dly,
  output logic [MAX_BITS-1:0] tx_word,
  output logic                start,
  output logic                dout_wr,
  output logic                done
);

  logic wr;
  logic hit_ctrl, hit_cfg, hit_txd, hit_rxd, hit_cause, hit_timing;
  logic clear_req;

  always_comb begin
    wr         = bus_valid & bus_write;
    hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
    hit_cfg    = (bus_addr == ADDR_W'(OFF_CFG));
    hit_txd    = (bus_addr == ADDR_W'(OFF_TXD));
    hit_rxd    = (bus_addr == ADDR_W'(OFF_RXD));
    hit_cause  = (bus_addr == ADDR_W'(OFF_CAUSE));
    hit_timing = (bus_addr == ADDR_W'(OFF_TIMING));
    dout_wr    = wr & hit_txd;
    start      = dout_wr & ~busy;
    clear_req  = wr & hit_cause & (bus_wdata == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_on   <= 1'b0;
      cs_idx  <= '0;
      mode    <= '0;
      smp_dly <= DLY_W'(DLY_RESET);
      tx_word <= '0;
      done    <= 1'b0;
    end else begin
      if (wr && hit_ctrl) begin
        cs_on  <= bus_wdata[CTRL_ON_BIT];
        cs_idx <= bus_wdata[CTRL_IDX_LO +: IDX_W];
      end
      if (wr && hit_cfg) begin
        mode.wide   <= bus_wdata[CFG_WIDE_BIT];
        mode.cpol   <= bus_wdata[CFG_CPOL_BIT];
        mode.cpha   <= bus_wdata[CFG_CPHA_BIT];
        mode.tx_lsb <= bus_wdata[CFG_TXLSB_BIT];
        mode.rx_lsb <= bus_wdata[CFG_RXLSB_BIT];
      end
      if (wr && hit_timing) smp_dly <= bus_wdata[TIM_DLY_LO +: DLY_W];
      if (start) tx_word <= bus_wdata[MAX_BITS-1:0];
      if (finish)         done <= 1'b1;
      else if (start)     done <= 1'b0;
      else if (clear_req) done <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CTRL_ON_BIT]            = cs_on;
      bus_rdata[CTRL_IDX_LO +: IDX_W]   = cs_idx;
    end else if (hit_cfg) begin
      bus_rdata[CFG_WIDE_BIT]  = mode.wide;
      bus_rdata[CFG_CPOL_BIT]  = mode.cpol;
      bus_rdata[CFG_CPHA_BIT]  = mode.cpha;
      bus_rdata[CFG_TXLSB_BIT] = mode.tx_lsb;
      bus_rdata[CFG_RXLSB_BIT] = mode.rx_lsb;
    end else if (hit_txd) begin
      bus_rdata[MAX_BITS-1:0] = tx_word;
    end else if (hit_rxd) begin
      bus_rdata[MAX_BITS-1:0] = rx_word;
    end else if (hit_cause) begin
      bus_rdata[0] = done;
    end else if (hit_timing) begin
      bus_rdata[TIM_DLY_LO +: DLY_W] = smp_dly;
    end
  end

endmodule

// File: rtl/regspi_engine.sv
module regspi_engine
  import regspi_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int NARROW_BITS = 8,
  parameter int DLY_W       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_in,
  input  mode_t               mode_in,
  input  logic [DLY_W-1:0]    dly_in,
  input  logic                half_tick,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                busy,
  output logic                finish,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                edge_evt,
  output logic                capture_evt,
  output logic                sclk_core,
  output logic                cpol_core,
  output logic [MAX_BITS-1:0] tx_core
);

  localparam int CNT_W     = $clog2(MAX_BITS + 1);
  localparam int ECNT_W    = $clog2(2 * MAX_BITS + 1);
  localparam int POS_W     = $clog2(MAX_BITS);
  localparam int DLY_DEPTH = (1 << DLY_W) - 1;

  logic                busy_q, sclk_q;
  mode_t               mode_q;
  logic [DLY_W-1:0]    dly_q;
  logic [CNT_W-1:0]    nbits_q, out_idx, rx_cnt;
  logic [ECNT_W-1:0]   edge_cnt;
  logic [MAX_BITS-1:0] tx_q, rx_q;
  logic [DLY_DEPTH:1]  pipe_q;
  logic [DLY_DEPTH:0]  taps;

  int   edge_k;
  logic edges_left, sample_evt, shift_evt;
  logic [POS_W-1:0] tx_pos, rx_pos;

  always_comb begin
    edge_k     = int'(edge_cnt) + 1;
    edges_left = int'(edge_cnt) < 2 * int'(nbits_q);
    edge_evt   = busy_q & half_tick & edges_left;
    sample_evt = edge_evt & is_sample_edge(edge_k, mode_q.cpha);
    shift_evt  = edge_evt & is_shift_edge(edge_k, int'(nbits_q), mode_q.cpha);
    tx_pos     = POS_W'(bit_slot(int'(out_idx), int'(nbits_q), mode_q.tx_lsb));
    rx_pos     = POS_W'(bit_slot(int'(rx_cnt), int'(nbits_q), mode_q.rx_lsb));
    finish     = busy_q & ~edges_left & (rx_cnt == nbits_q);
  end

  // tap 0 is the sampling edge itself, tap i is i cycles later
  assign taps[0] = sample_evt;
  for (genvar g = 1; g <= DLY_DEPTH; g++) begin : g_tap
    assign taps[g] = pipe_q[g];
  end
  assign capture_evt = busy_q & taps[dly_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[1] <= sample_evt;
      for (int i = 2; i <= DLY_DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mode_q   <= '0;
      dly_q    <= '0;
      nbits_q  <= CNT_W'(NARROW_BITS);
      out_idx  <= '0;
      rx_cnt   <= '0;
      edge_cnt <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      sclk_q   <= mode_in.cpol;
      mode_q   <= mode_in;
      dly_q    <= dly_in;
      nbits_q  <= CNT_W'(word_bits(mode_in.wide, NARROW_BITS, MAX_BITS));
      out_idx  <= '0;
      rx_cnt   <= '0;
      edge_cnt <= '0;
      tx_q     <= tx_in;
      rx_q     <= '0;
    end else if (busy_q) begin
      if (edge_evt) begin
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + 1'b1;
      end
      if (shift_evt) out_idx <= out_idx + 1'b1;
      if (capture_evt) begin
        rx_q[rx_pos] <= miso;
        rx_cnt       <= rx_cnt + 1'b1;
      end
      if (finish) busy_q <= 1'b0;
    end
  end

  assign sclk      = busy_q ? sclk_q : mode_in.cpol;
  assign mosi      = busy_q ? tx_q[tx_pos] : 1'b0;
  assign busy      = busy_q;
  assign rx_word   = rx_q;
  assign sclk_core = sclk_q;
  assign cpol_core = mode_q.cpol;
  assign tx_core   = tx_q;

endmodule

// File: rtl/regspi_csdec.sv
module regspi_csdec #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 3
) (
  input  logic              cs_on,
  input  logic [IDX_W-1:0]  cs_idx,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = ~(cs_on & (cs_idx == IDX_W'(i)));
  end

endmodule

// File: rtl/regspi_master.sv
module regspi_master
  import regspi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_CS      = 8,
  parameter int MAX_BITS    = 16,
  parameter int NARROW_BITS = 8,
  parameter int DLY_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              half_tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int IDX_W = $clog2(NUM_CS);

  logic                cs_on_w;
  logic [IDX_W-1:0]    cs_idx_w;
  mode_t               mode_w;
  logic [DLY_W-1:0]    dly_w;
  logic [MAX_BITS-1:0] tx_word_w, rx_word_w, tx_core_w;
  logic                start_w, dout_wr_w, done_w, busy_w, finish_w;
  logic                edge_evt_w, capture_evt_w, sclk_core_w, cpol_core_w;

  regspi_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .MAX_BITS(MAX_BITS), .DLY_W(DLY_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy_w), .finish(finish_w), .rx_word(rx_word_w),
    .cs_on(cs_on_w), .cs_idx(cs_idx_w), .mode(mode_w), .smp_dly(dly_w),
    .tx_word(tx_word_w), .start(start_w), .dout_wr(dout_wr_w), .done(done_w)
  );

  regspi_engine #(
    .MAX_BITS(MAX_BITS), .NARROW_BITS(NARROW_BITS), .DLY_W(DLY_W)
  ) engine_i (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .tx_in(bus_wdata[MAX_BITS-1:0]), .mode_in(mode_w),
    .dly_in(dly_w), .half_tick(half_tick), .miso(miso),
    .sclk(sclk), .mosi(mosi), .busy(busy_w), .finish(finish_w),
    .rx_word(rx_word_w), .edge_evt(edge_evt_w), .capture_evt(capture_evt_w),
    .sclk_core(sclk_core_w), .cpol_core(cpol_core_w), .tx_core(tx_core_w)
  );

  regspi_csdec #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) csdec_i (
    .cs_on(cs_on_w), .cs_idx(cs_idx_w), .cs_n(cs_n)
  );

endmodule

// File: rtl/regspi_master_chk.sv
module regspi_master_chk #(
  parameter int NUM_CS   = 8,
  parameter int MAX_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                sclk_core,
  input logic                cpol_core,
  input logic                half_tick,
  input logic                edge_evt,
  input logic                capture_evt,
  input logic                cs_on,
  input logic [NUM_CS-1:0]   cs_n,
  input logic                dout_wr,
  input logic [MAX_BITS-1:0] tx_core
);

  assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |-> (cs_n == '1));

  assert_sclk_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && (sclk_core != $past(sclk_core)) |-> $past(half_tick));

  assert_sclk_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk_core == cpol_core));

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dout_wr |=> $stable(tx_core));

  assert_capture_in_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> busy);

  assert_edges_in_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> busy && half_tick);

endmodule

bind regspi_master regspi_master_chk #(.NUM_CS(NUM_CS), .MAX_BITS(MAX_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w),
  .sclk_core(sclk_core_w), .cpol_core(cpol_core_w), .half_tick(half_tick),
  .edge_evt(edge_evt_w), .capture_evt(capture_evt_w), .cs_on(cs_on_w),
  .cs_n(cs_n), .dout_wr(dout_wr_w), .tx_core(tx_core_w)
);

// File: tb/regspi_master_tb_top.sv
module regspi_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_TXD = 8'h08,
                         A_RXD = 8'h0C, A_CAUSE = 8'h10, A_TIM = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        half_tick = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, mosi;
  logic [7:0]  cs_n;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;
  int tick_cnt = 0;

  regspi_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .half_tick(half_tick), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stand-in for the external divider: one enable every HALF cycles
  always @(negedge clk) begin
    if (tick_cnt == HALF - 1) begin
      tick_cnt  <= 0;
      half_tick <= 1'b1;
    end else begin
      tick_cnt  <= tick_cnt + 1;
      half_tick <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // expected received word: capture j takes seq[j], or the bit before it when late
  function automatic logic [15:0] exp_rx(logic [15:0] seq, int n, bit rxl, bit shifted, bit p);
    logic [15:0] r = '0;
    for (int j = 0; j < n; j++) begin
      logic c;
      c = shifted ? ((j == 0) ? p : seq[j-1]) : seq[j];
      if (rxl) r[j] = c;
      else     r = {r[14:0], c};
    end
    return r;
  endfunction

  // rebuild the transmitted word from the bits seen on the wire
  function automatic logic [15:0] wire_word(logic [15:0] cap, int n, bit txl);
    logic [15:0] w = '0;
    for (int j = 0; j < n; j++) begin
      if (txl) w[j] = cap[j];
      else     w = {w[14:0], cap[j]};
    end
    return w;
  endfunction

  task automatic run_xfer(input bit wide, input bit cpol, input bit cpha, input bit txl,
                          input bit rxl, input logic [1:0] dly, input bit late,
                          input logic [15:0] tx, input logic [15:0] seq, input bit p,
                          input int inj_at, input logic [15:0] inj_val, input string tag);
    int n, k, m, nxt;
    bit pend, prev, got_done;
    logic [15:0] cap, mask, exp_w;
    logic [31:0] d;
    n = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    wr(A_CFG, (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
              (32'(txl) << 13) | (32'(rxl) << 14));
    wr(A_TIM, 32'(dly) << 6);
    k = 0; m = 0; pend = 1'b0; cap = '0; got_done = 1'b0;
    if (!late && !cpha) begin miso = seq[0]; nxt = 1; end
    else begin miso = p; nxt = 0; end
    wr(A_TXD, {16'hDEAD, tx});
    prev = sclk;
    for (int it = 0; it < 2000; it++) begin
      @(negedge clk);
      if (pend) begin
        if (nxt < n) miso = seq[nxt];
        nxt++;
        pend = 1'b0;
      end
      if (sclk !== prev) begin
        k++;
        if (((k % 2) == 1) != cpha) begin
          if (m < 16) cap[m] = mosi;
          m++;
          if (late) pend = 1'b1;
        end else if (!late) begin
          if (nxt < n) miso = seq[nxt];
          nxt++;
        end
      end
      prev = sclk;
      if (it == inj_at) begin
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_TXD; bus_wdata = {16'h0, inj_val};
      end else begin
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = A_CAUSE;
        #1;
        if (bus_rdata != 0) begin got_done = 1'b1; break; end
      end
    end
    chk(got_done, "R8 done after word", 32'(got_done), 32'd1);
    rd(A_RXD, d);
    exp_w = exp_rx(seq, n, rxl, late && (dly < 2), p);
    chk(d == {16'h0, exp_w}, tag, d, {16'h0, exp_w});
    chk(wire_word(cap, n, txl) == (tx & mask), "R5 mosi order/phase",
        32'(wire_word(cap, n, txl)), 32'(tx & mask));
    chk(k == 2 * n, "R4 sclk transitions", k, 2 * n);
    chk(sclk == cpol, "R4 sclk back at cpol", 32'(sclk), 32'(cpol));
    if (inj_at >= 0) begin
      rd(A_TXD, d);
      chk(d == {16'h0, tx}, "R10 txd unchanged by busy write", d, {16'h0, tx});
    end
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, d);
    chk(d == 32'h0, "R9 zero write clears done", d, 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(cs_n == 8'hFF, "R1 cs_n after reset", 32'(cs_n), 32'hFF);
    chk(sclk == 1'b0, "R1 sclk after reset", 32'(sclk), 32'h0);
    chk(mosi == 1'b0, "R1 mosi after reset", 32'(mosi), 32'h0);
    rd(A_CAUSE, d); chk(d == 32'h0, "R1 done after reset", d, 32'h0);
    rd(A_RXD, d);   chk(d == 32'h0, "R1 rx after reset", d, 32'h0);
    rd(A_TIM, d);   chk(d == 32'h40, "R1 timing after reset", d, 32'h40);

    // R2 field read-back
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d);
    chk(d == 32'h1D, "R2 control readback", d, 32'h1D);
    wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, d);
    chk(d == 32'h7820, "R2 config readback", d, 32'h7820);
    wr(A_TIM, 32'hFFFF_FFFF); rd(A_TIM, d);
    chk(d == 32'hC0, "R2 timing readback", d, 32'hC0);
    wr(A_CFG, 32'h0);

    // R3 chip-select sweep
    for (int i = 0; i < 8; i++) begin
      for (int on = 0; on < 2; on++) begin
        logic [7:0] e;
        wr(A_CTRL, (32'(i) << 2) | 32'(on));
        @(negedge clk);
        e = on ? ~(8'h1 << i) : 8'hFF;
        chk(cs_n == e, "R3 chip select decode", 32'(cs_n), 32'(e));
      end
    end
    wr(A_CTRL, (32'd3 << 2) | 32'd1);

    // directed words
    run_xfer(0, 0, 0, 0, 0, 2'd1, 0, 16'h00A5, 16'h003C, 0, -1, 0, "R6 msb-first rx mode0");
    run_xfer(0, 1, 1, 1, 1, 2'd0, 0, 16'h0013, 16'h00C4, 1, -1, 0, "R6 lsb-first rx mode3");
    run_xfer(1, 0, 1, 1, 0, 2'd3, 0, 16'hBEEF, 16'h1234, 0, -1, 0, "R7 16-bit word");
    run_xfer(0, 1, 0, 0, 1, 2'd2, 0, 16'hFF5A, 16'hFF96, 1, -1, 0, "R7 8-bit upper bits zero");

    // R11 late slave in mode 3: delays 0/1 see the word shifted, 2/3 see it intact
    for (int dl = 0; dl < 4; dl++) begin
      run_xfer(1, 1, 1, 0, 0, 2'(dl), 1, 16'h0F0F, 16'hA6C3, 1, -1, 0, "R11 capture delay");
    end

    // R10 write to the transmit register mid-word
    run_xfer(1, 0, 0, 0, 0, 2'd1, 0, 16'h5AA5, 16'h0FF0, 0, 40, 16'h1111, "R10 rx unaffected");

    // R9 nonzero write leaves done set
    wr(A_TXD, 32'h0000_0077);
    for (int it = 0; it < 2000; it++) begin
      rd(A_CAUSE, d);
      if (d != 0) break;
    end
    chk(d == 32'h1, "R8 done set", d, 32'h1);
    wr(A_CAUSE, 32'h5);
    rd(A_CAUSE, d);
    chk(d == 32'h1, "R9 nonzero write keeps done", d, 32'h1);
    wr(A_CAUSE, 32'h0);

    // random configurations
    for (int t = 0; t < 40; t++) begin
      logic [31:0] r;
      r = $urandom;
      run_xfer(r[0], r[1], r[2], r[3], r[4], r[6:5], 0, 16'($urandom), 16'($urandom), r[7],
               -1, 0, "R6 R7 random word");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule